// File: doc/BRIEF.md
# Parameter-Area Checksum Engine

This block walks a fixed window of a byte-wide parameter memory, folds its contents into a 16-bit checksum, and stores the checksum back into the same memory. A single-cycle `start` pulse launches a pass. The engine reads the bytes through a plain read/write port that has one cycle of read latency. It writes the two result bytes to a fixed location and then raises `done` for one cycle.

The checksum register is seeded with 0xFFFF. Every update step combines the register with a 16-bit word through a nibble-folded shift/XOR step. A word is formed from two neighbouring bytes, with the lower offset in the upper half. The step index moves forward one byte at a time, so consecutive words share a byte. When the window length is odd, one more step uses the trailing byte padded with a zero low byte. The window base, the window length, the result location and the address width are elaboration-time parameters. By default the window is offsets 0x00..0xF7 and the result goes to 0xFC/0xFD.

Top module: `nvsum_engine`

## Requirements
- R1: While reset is held, and after it is released with no start, `done`, `memRd` and `memWr` are all 0.
- R2: The checksum starts at 0xFFFF. Each step with word w replaces c with (c>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), truncated to 16 bits, where e = c^w, a = e[3:0] and b = e[7:4]^a.
- R3: For a window of N bytes at base B, floor(N/2)*2 word steps are made. Step i (from 0) uses word {mem[B+i], mem[B+i+1]}, and each step issues two reads, so a pass makes 2*floor(N/2)*2 word reads.
- R4: When N is odd, one extra step follows with word {mem[B+N-1], 8'h00}, which takes one more read.
- R5: The result is written exactly twice per pass: the high byte to SUM_AT, then on the next cycle the low byte to SUM_AT+1.
- R6: `done` is high for exactly one cycle, in the cycle right after the low result byte is written.
- R7: A `start` that arrives while a pass is running has no effect. The pass finishes with the normal result and timing, and no further pass follows.
- R8: Reads only target offsets B..B+2*floor(N/2). Read and write are never asserted together, and no memory byte other than the two result bytes is modified.
- R9: With S = 2*floor(N/2) and T = N mod 2, `done` is first high 4*S + 2*T + 2 cycles after the clock edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a pass; taken only when idle |
| memAddr | output | ADDR_W | Byte address for read or write |
| memRd | output | 1 | Read request; data returns on memRdata one cycle later |
| memWr | output | 1 | Write request for memWdata at memAddr |
| memWdata | output | 8 | Result byte being written |
| memRdata | input | 8 | Read data, valid the cycle after memRd |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds three instances. The first uses the default 248-byte window at base 0 with an 8-bit address. The second uses a 13-byte window at base 5 with a 6-bit address, and the third uses a 1-byte window at base 2 with a 4-bit address. Together they cover an even window, an odd window with a trailing pad step, and the degenerate case of no word steps and only the pad step. Each instance runs all-zero, all-ones, alternating and random memory images and compares the stored checksum with an arithmetic model. The same runs also compare the pass latency, the read count, the read range, the write order and the memory left untouched, and every run fires a stray start in the middle of the pass.

// File: rtl/nvsum_pkg.sv
package nvsum_pkg;

  // Address source selected by the controller
  typedef enum logic [1:0] {
    ADR_CUR  = 2'd0,  // base + index
    ADR_NEXT = 2'd1,  // base + index + 1
    ADR_SUMH = 2'd2,  // result high byte
    ADR_SUML = 2'd3   // result low byte
  } adrSelT;

  // Strobes from control to datapath
  typedef struct packed {
    logic   init;      // seed checksum, clear index
    logic   latchHi;   // capture returned byte as word high half
    logic   stepWord;  // fold {hi, returned byte}
    logic   stepTail;  // fold {returned byte, 8'h00}
    logic   advance;   // index + 1
    adrSelT adrSel;
  } strobeT;

  // One nibble-folded checksum step
  function automatic logic [15:0] crcStep(input logic [15:0] prev, input logic [15:0] word);
    logic [15:0] d, n1, n2;
    d  = prev ^ word;
    n1 = {12'h000, d[3:0]};
    n2 = {12'h000, d[7:4] ^ d[3:0]};
    return (prev >> 8) ^ (n1 << 3) ^ (n1 << 8) ^ n2 ^ (n2 << 7) ^ (n2 << 12);
  endfunction

endpackage

// File: rtl/nvsum_ctrl.sv
module nvsum_ctrl
  import nvsum_pkg::*;
#(
  parameter int WORD_STEPS = 248,
  parameter int HAS_TAIL   = 0
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   lastWord,
  output strobeT stb,
  output logic   memRd,
  output logic   memWr,
  output logic   done
);

  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_RHI   = 4'd1,
    S_CHI   = 4'd2,
    S_RLO   = 4'd3,
    S_CLO   = 4'd4,
    S_RTAIL = 4'd5,
    S_CTAIL = 4'd6,
    S_WHI   = 4'd7,
    S_WLO   = 4'd8,
    S_FIN   = 4'd9
  } stateT;

  localparam stateT AFTER_WORDS = (HAS_TAIL != 0) ? S_RTAIL : S_WHI;
  localparam stateT AFTER_START = (WORD_STEPS > 0) ? S_RHI : AFTER_WORDS;

  stateT state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    stb.adrSel = ADR_CUR;
    memRd     = 1'b0;
    memWr     = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stb.init  = 1'b1;
          nextState = AFTER_START;
        end
      end
      S_RHI: begin
        memRd      = 1'b1;
        stb.adrSel = ADR_CUR;
        nextState  = S_CHI;
      end
      S_CHI: begin
        stb.latchHi = 1'b1;
        nextState   = S_RLO;
      end
      S_RLO: begin
        memRd      = 1'b1;
        stb.adrSel = ADR_NEXT;
        nextState  = S_CLO;
      end
      S_CLO: begin
        stb.stepWord = 1'b1;
        stb.advance  = 1'b1;
        nextState    = lastWord ? AFTER_WORDS : S_RHI;
      end
      S_RTAIL: begin
        memRd      = 1'b1;
        stb.adrSel = ADR_CUR;
        nextState  = S_CTAIL;
      end
      S_CTAIL: begin
        stb.stepTail = 1'b1;
        nextState    = S_WHI;
      end
      S_WHI: begin
        memWr      = 1'b1;
        stb.adrSel = ADR_SUMH;
        nextState  = S_WLO;
      end
      S_WLO: begin
        memWr      = 1'b1;
        stb.adrSel = ADR_SUML;
        nextState  = S_FIN;
      end
      S_FIN: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memWr)); // R6

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R8

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != S_IDLE && state != S_FIN) |=> (state != S_IDLE && !stb.init)); // R7

endmodule

// File: rtl/nvsum_dp.sv
module nvsum_dp
  import nvsum_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int AREA_BASE  = 0,
  parameter int WORD_STEPS = 248,
  parameter int SUM_AT     = 252
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              lastWord
);

  localparam int IDX_W  = $clog2(WORD_STEPS + 2);
  localparam int LAST_I = (WORD_STEPS > 0) ? WORD_STEPS - 1 : 0;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(AREA_BASE);
  localparam logic [ADDR_W-1:0] SUMH_A = ADDR_W'(SUM_AT);
  localparam logic [ADDR_W-1:0] SUML_A = ADDR_W'(SUM_AT + 1);

  logic [15:0]      crcReg;
  logic [7:0]       hiByte;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= 16'hFFFF;
      hiByte <= 8'h00;
      idx    <= '0;
    end else begin
      if (stb.init) begin
        crcReg <= 16'hFFFF;
        idx    <= '0;
      end
      if (stb.latchHi)  hiByte <= memRdata;
      if (stb.stepWord) crcReg <= crcStep(crcReg, {hiByte, memRdata});
      if (stb.stepTail) crcReg <= crcStep(crcReg, {memRdata, 8'h00});
      if (stb.advance)  idx    <= idx + 1'b1;
    end
  end

  assign lastWord = (idx == IDX_W'(LAST_I));

  always_comb begin
    unique case (stb.adrSel)
      ADR_CUR:  memAddr = BASE_A + ADDR_W'(idx);
      ADR_NEXT: memAddr = BASE_A + ADDR_W'(idx) + 1'b1;
      ADR_SUMH: memAddr = SUMH_A;
      ADR_SUML: memAddr = SUML_A;
      default:  memAddr = BASE_A;
    endcase
  end

  assign memWdata = (stb.adrSel == ADR_SUML) ? crcReg[7:0] : crcReg[15:8];

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    idx <= IDX_W'(WORD_STEPS)); // R3

  AST_HI_BEFORE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepWord |-> $past(stb.latchHi, 2)); // R3

  AST_SEED_AFTER_INIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.init |=> (crcReg == 16'hFFFF && idx == '0)); // R2

endmodule

// File: rtl/nvsum_engine.sv
module nvsum_engine
  import nvsum_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int AREA_BASE = 0,
  parameter int AREA_LEN  = 248,
  parameter int SUM_AT    = 252
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              done
);

  localparam int WORD_STEPS = AREA_LEN - (AREA_LEN % 2);
  localparam int HAS_TAIL   = AREA_LEN % 2;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(AREA_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(WORD_STEPS);
  localparam logic [ADDR_W-1:0] SUMH_A = ADDR_W'(SUM_AT);
  localparam logic [ADDR_W-1:0] SUML_A = ADDR_W'(SUM_AT + 1);

  strobeT stb;
  logic   lastWord;

  nvsum_ctrl #(
    .WORD_STEPS(WORD_STEPS),
    .HAS_TAIL  (HAS_TAIL)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lastWord(lastWord),
    .stb     (stb),
    .memRd   (memRd),
    .memWr   (memWr),
    .done    (done)
  );

  nvsum_dp #(
    .ADDR_W    (ADDR_W),
    .AREA_BASE (AREA_BASE),
    .WORD_STEPS(WORD_STEPS),
    .SUM_AT    (SUM_AT)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .lastWord(lastWord)
  );

  AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (memAddr == SUMH_A || memAddr == SUML_A)); // R5

  AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && memAddr == SUML_A) |-> ($past(memWr) && $past(memAddr) == SUMH_A)); // R5

  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> ((memAddr - BASE_A) <= SPAN_A)); // R8

endmodule

// File: tb/sim_nvsum_engine.sv
module sim_nvsum_case #(
  parameter int AW   = 8,
  parameter int BASE = 0,
  parameter int LEN  = 248,
  parameter int SUM  = 252,
  parameter int RUNS = 4
) (
  input  logic clk,
  input  logic rstN,
  output int   errs,
  output int   checks,
  output logic finished
);

  localparam int MEMN = 1 << AW;
  localparam int S    = LEN - (LEN % 2);
  localparam int T    = LEN % 2;

  logic          start;
  logic [AW-1:0] memAddr;
  logic          memRd, memWr, done;
  logic [7:0]    memWdata, memRdata;
  logic [7:0]    mem    [0:MEMN-1];
  logic [7:0]    shadow [0:MEMN-1];

  int rdN, rdBad, wrN;
  int wrPrevA, wrPrevD, wrLastA, wrLastD;

  nvsum_engine #(
    .ADDR_W(AW), .AREA_BASE(BASE), .AREA_LEN(LEN), .SUM_AT(SUM)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .memAddr(memAddr),
    .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memRdata(memRdata), .done(done)
  );

  // Byte memory with one cycle of read latency
  always @(posedge clk) begin
    if (memRd) memRdata <= mem[memAddr];
    if (memWr) mem[memAddr] <= memWdata;
  end

  // Bus monitor, cumulative counts
  initial begin
    rdN = 0; rdBad = 0; wrN = 0;
    wrPrevA = 0; wrPrevD = 0; wrLastA = 0; wrLastD = 0;
  end
  always @(posedge clk) begin
    if (rstN && memRd) begin
      rdN <= rdN + 1;
      if (int'(memAddr) < BASE || int'(memAddr) > BASE + S) rdBad <= rdBad + 1;
    end
    if (rstN && memWr) begin
      wrN     <= wrN + 1;
      wrPrevA <= wrLastA;
      wrPrevD <= wrLastD;
      wrLastA <= int'(memAddr);
      wrLastD <= int'(memWdata);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s [len %0d] %s: actual=%0h expected=%0h", req, LEN, what, act, exp);
    end
  endtask

  function automatic int fold(input int c, input int w);
    int e, a, b;
    e = (c ^ w) & 16'hFFFF;
    a = e & 15;
    b = ((e >> 4) & 15) ^ a;
    return ((c >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12)) & 16'hFFFF;
  endfunction

  function automatic int model();
    int c;
    c = 16'hFFFF;
    for (int i = 0; i < S; i++)
      c = fold(c, (int'(mem[(BASE + i) % MEMN]) << 8) | int'(mem[(BASE + i + 1) % MEMN]));
    if (T != 0) c = fold(c, int'(mem[(BASE + S) % MEMN]) << 8);
    return c;
  endfunction

  initial begin
    errs = 0; checks = 0; finished = 1'b0; start = 1'b0;
    for (int k = 0; k < MEMN; k++) mem[k] = 8'h00;
    @(negedge clk);
    chk(!done && !memRd && !memWr, "R1", "outputs in reset", {done, memRd, memWr}, 0);
    wait (rstN);
    repeat (3) @(negedge clk);
    chk(!done && !memRd && !memWr, "R1", "idle after reset", {done, memRd, memWr}, 0);

    for (int run = 0; run < RUNS; run++) begin
      int expSum, cyc, rd0, wr0, diffs;
      for (int k = 0; k < MEMN; k++) begin
        case (run)
          0:       mem[k] = 8'h00;
          1:       mem[k] = 8'hFF;
          2:       mem[k] = (k % 2 != 0) ? 8'hA5 : 8'h5A;
          default: mem[k] = 8'($urandom);
        endcase
        shadow[k] = mem[k];
      end
      expSum = model();
      rd0 = rdN; wr0 = wrN;

      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cyc = 1;
      while (!done && cyc < 5000) begin
        @(negedge clk);
        cyc++;
        if (cyc == 2) start = 1'b1;   // stray start mid-pass (R7)
        if (cyc == 3) start = 1'b0;
      end
      chk(cyc == 4 * S + 2 * T + 3, "R9", "cycles to done", cyc, 4 * S + 2 * T + 3);
      @(negedge clk);
      chk(!done, "R6", "done one cycle", int'(done), 0);
      chk(int'(mem[(SUM) % MEMN]) == (expSum >> 8), (T != 0) ? "R4" : "R2", "sum high byte",
          int'(mem[SUM % MEMN]), expSum >> 8);
      chk(int'(mem[(SUM + 1) % MEMN]) == (expSum & 255), (T != 0) ? "R4" : "R2", "sum low byte",
          int'(mem[(SUM + 1) % MEMN]), expSum & 255);
      chk(wrN - wr0 == 2, "R5", "write count", wrN - wr0, 2);
      chk(wrPrevA == SUM && wrLastA == SUM + 1, "R5", "write order", wrPrevA, SUM);
      chk(wrPrevD == (expSum >> 8) && wrLastD == (expSum & 255), "R5", "written bytes",
          (wrPrevD << 8) | wrLastD, expSum);
      chk(rdN - rd0 == 2 * S + T, (T != 0) ? "R4" : "R3", "read count", rdN - rd0, 2 * S + T);
      diffs = 0;
      for (int k = 0; k < MEMN; k++)
        if (k != SUM && k != SUM + 1 && mem[k] != shadow[k]) diffs++;
      chk(diffs == 0 && rdBad == 0, "R8", "stray access", diffs + rdBad, 0);
      rd0 = rdN;
      repeat (6) @(negedge clk);
      chk(rdN == rd0 && !done && !memWr, "R7", "no second pass", rdN - rd0, 0);
    end
    finished = 1'b1;
  end

endmodule

module sim_nvsum_engine;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int   e0, c0, e1, c1, e2, c2;
  logic f0, f1, f2;
  int   cycCount = 0;

  always @(posedge clk) cycCount <= cycCount + 1;

  sim_nvsum_case #(.AW(8), .BASE(0), .LEN(248), .SUM(252), .RUNS(5))
    h0 (.clk(clk), .rstN(rstN), .errs(e0), .checks(c0), .finished(f0));
  sim_nvsum_case #(.AW(6), .BASE(5), .LEN(13), .SUM(40), .RUNS(10))
    h1 (.clk(clk), .rstN(rstN), .errs(e1), .checks(c1), .finished(f1));
  sim_nvsum_case #(.AW(4), .BASE(2), .LEN(1), .SUM(9), .RUNS(6))
    h2 (.clk(clk), .rstN(rstN), .errs(e2), .checks(c2), .finished(f2));

  initial begin
    int errs, total;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    wait ((f0 && f1 && f2) || cycCount >= 150000);
    @(negedge clk);
    errs  = e0 + e1 + e2;
    total = c0 + c1 + c2;
    if (!(f0 && f1 && f2)) begin
      errs++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycCount, 150000);
    end
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule